// File: doc/BRIEF.md
# Shift-and-Add Array Multiplier

This block multiplies two unsigned operands with no clock and no registers. It is built gate by gate rather than from a multiply operator. Each bit of the multiplier selects the multiplicand through a row of AND gates, which gives one partial-product row per multiplier bit. Rows after the first sit one bit further to the left. Each row is added into the upper bits of the running total by a ripple row of full and half adders.

The lowest bit of every adder row is finished as soon as that row settles, so it becomes one product bit. The last row gives the upper half of the product, and its final carry is the most significant product bit. The operand widths are parameters and default to 4 bits each, which gives an 8-bit product.

A wider datapath instantiates the block wherever a small exact product is needed and a cycle of latency is not acceptable.

Top module: `shadd_array_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod_o` equals the arithmetic product of `mcand_i` and `mplier_i`, with the product `MCAND_W + MPLIER_W` bits wide (8 bits by default).
- R2: Product bit 0 equals `mcand_i[0] AND mplier_i[0]`.
- R3: When either operand is zero, `prod_o` is all zeros.
- R4: When `mplier_i` equals 1, `prod_o` equals `mcand_i` zero-extended to the full product width.
- R5: When `mplier_i` has a single bit k set, `prod_o` equals `mcand_i` shifted left by k positions.
- R6: The product never exceeds the product of the two all-ones operands. For 4-bit operands, 15 times 15 gives 225 (0xE1), and the final adder carry sets bit 7.
- R7: Swapping the two operand values leaves `prod_o` unchanged.
- R8: The output is purely combinational. A new operand pair is reflected on `prod_o` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | MCAND_W (4) | Unsigned multiplicand |
| mplier_i | input | MPLIER_W (4) | Unsigned multiplier; each bit selects one partial-product row |
| prod_o | output | MCAND_W+MPLIER_W (8) | Unsigned product |

## Verification
The bench concentrates on the carry paths.

- The all-ones pair drives the longest carry ripple into bit 7. A row that dropped its carry-out, or a top cell wired as a half adder where three bits meet, would give a value below 225.
- Powers of two in the multiplier catch a row that is shifted by the wrong amount, because the product then moves off by a factor of two.
- Swapped operand pairs expose an asymmetric wiring slip, such as a partial-product bit taken from the wrong index.
- The complete sweep of all operand pairs catches a single flipped AND gate or a mis-wired sum, anywhere in the array.

// File: rtl/shadd_mult_pkg.sv
package shadd_mult_pkg;

  // Shift-and-add golden product, used only by the checks.
  function automatic logic [63:0] shadd_ref(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input int          bw);
    logic [63:0] acc;
    acc = '0;
    for (int i = 0; i < bw; i++) begin
      if (b[i]) acc = acc + (64'(a) << i);
    end
    return acc;
  endfunction

endpackage

// File: rtl/shadd_half_add.sv
module shadd_half_add (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;
endmodule

// File: rtl/shadd_full_add.sv
module shadd_full_add (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = a ^ b;
  assign s  = p ^ ci;
  assign co = (a & b) | (p & ci);
endmodule

// File: rtl/shadd_pp_gen.sv
module shadd_pp_gen #(
  parameter int N = 4,
  parameter int M = 4
) (
  input  logic [N-1:0]        mcand,
  input  logic [M-1:0]        mplier,
  output logic [M-1:0][N-1:0] pp
);
  for (genvar r = 0; r < M; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      assign pp[r][c] = mcand[c] & mplier[r];
    end
  end
endmodule

// File: rtl/shadd_add_row.sv
// One adder row: adds a partial-product row to the upper bits of the
// running total. The first row has no carry entering its top position.
module shadd_add_row #(
  parameter int W     = 4,
  parameter bit FIRST = 1'b0,
  localparam int PW   = FIRST ? W - 1 : W,
  localparam int XW   = W + 1
) (
  input  logic [PW-1:0] prev,
  input  logic [W-1:0]  pp,
  output logic [W-1:0]  sum,
  output logic          cout
);
  logic [W-1:0] cy;

  for (genvar k = 0; k < W; k++) begin : g_cell
    if (k == 0) begin : g_lsb
      shadd_half_add u_ha (.a(prev[0]), .b(pp[0]), .s(sum[0]), .co(cy[0]));
    end else if (k == W - 1 && FIRST) begin : g_top_ha
      shadd_half_add u_ha (.a(pp[k]), .b(cy[k-1]), .s(sum[k]), .co(cy[k]));
    end else begin : g_fa
      // The partial-product bit enters on the carry-in pin.
      shadd_full_add u_fa (.a(prev[k]), .b(cy[k-1]), .ci(pp[k]),
                           .s(sum[k]), .co(cy[k]));
    end
  end

  assign cout = cy[W-1];

  // The row's output must equal the arithmetic sum of its two addends.
  always_comb begin
    a_r1_row_sum: assert ({cout, sum} == XW'(prev) + XW'(pp))
      else $error("row sum mismatch");
  end
endmodule

// File: rtl/shadd_array_mult.sv
module shadd_array_mult #(
  parameter int MCAND_W  = 4,
  parameter int MPLIER_W = 4,
  localparam int P_W     = MCAND_W + MPLIER_W
) (
  input  logic [MCAND_W-1:0]  mcand_i,
  input  logic [MPLIER_W-1:0] mplier_i,
  output logic [P_W-1:0]      prod_o
);
  import shadd_mult_pkg::*;

  localparam logic [63:0] PMAX =
    shadd_ref({32{1'b1}} >> (32 - MCAND_W), {32{1'b1}} >> (32 - MPLIER_W), MPLIER_W);

  logic [MPLIER_W-1:0][MCAND_W-1:0] pp;
  logic [MCAND_W-1:0]               rsum  [1:MPLIER_W-1];
  logic                             rcout [1:MPLIER_W-1];

  shadd_pp_gen #(.N(MCAND_W), .M(MPLIER_W)) u_pp (
    .mcand (mcand_i),
    .mplier(mplier_i),
    .pp    (pp)
  );

  for (genvar r = 1; r < MPLIER_W; r++) begin : g_rows
    if (r == 1) begin : g_first
      shadd_add_row #(.W(MCAND_W), .FIRST(1'b1)) u_row (
        .prev(pp[0][MCAND_W-1:1]),
        .pp  (pp[1]),
        .sum (rsum[1]),
        .cout(rcout[1])
      );
    end else begin : g_next
      shadd_add_row #(.W(MCAND_W), .FIRST(1'b0)) u_row (
        .prev({rcout[r-1], rsum[r-1][MCAND_W-1:1]}),
        .pp  (pp[r]),
        .sum (rsum[r]),
        .cout(rcout[r])
      );
    end
    assign prod_o[r] = rsum[r][0];
  end

  assign prod_o[0]         = pp[0][0];
  assign prod_o[P_W-1:MPLIER_W] = {rcout[MPLIER_W-1], rsum[MPLIER_W-1][MCAND_W-1:1]};

  logic [63:0] ref_full;
  assign ref_full = shadd_ref(32'(mcand_i), 32'(mplier_i), MPLIER_W);

  always_comb begin
    a_r1_product: assert (64'(prod_o) == ref_full)
      else $error("product mismatch");
    if (mcand_i == '0 || mplier_i == '0) begin
      a_r3_zero_operand: assert (prod_o == '0) else $error("zero operand");
    end
    if (mplier_i == MPLIER_W'(1)) begin
      a_r4_identity: assert (prod_o == P_W'(mcand_i)) else $error("identity");
    end
    for (int k = 0; k < MPLIER_W; k++) begin
      if (mplier_i == (MPLIER_W'(1) << k)) begin
        a_r5_pow2_shift: assert (prod_o == (P_W'(mcand_i) << k))
          else $error("power-of-two shift");
      end
    end
    a_r6_bound: assert (64'(prod_o) <= PMAX) else $error("bound exceeded");
  end
endmodule

// File: tb/shadd_array_mult_test.sv
module shadd_array_mult_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 4;
  localparam int NB = 4;
  localparam int NP = NA + NB;

  logic          clk = 1'b0;
  logic [NA-1:0] a;
  logic [NB-1:0] b;
  logic [NP-1:0] p;
  int            n_run  = 0;
  int            n_fail = 0;
  bit            done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadd_array_mult #(.MCAND_W(NA), .MPLIER_W(NB)) uut (
    .mcand_i (a),
    .mplier_i(b),
    .prod_o  (p)
  );

  // Expected value by repeated addition.
  function automatic logic [NP-1:0] exp_prod(input int x, input int y);
    int acc = 0;
    for (int j = 0; j < y; j++) acc += x;
    return NP'(acc);
  endfunction

  task automatic chk(input string req, input logic [NP-1:0] act,
                     input logic [NP-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (a=%0d b=%0d)",
               req, act, exp, a, b);
    end
  endtask

  task automatic apply(input int x, input int y);
    @(negedge clk);
    a = NA'(x);
    b = NB'(y);
    #1;
  endtask

  task automatic t_zero_state;
    apply(0, 0);
    chk("R3 all-zero inputs", p, '0);
    apply(13, 0);
    chk("R3 zero multiplier", p, '0);
    apply(0, 11);
    chk("R3 zero multiplicand", p, '0);
  endtask

  task automatic t_identity;
    for (int x = 0; x < 16; x += 5) begin
      apply(x, 1);
      chk("R4 multiply by one", p, NP'(x));
    end
  endtask

  task automatic t_pow2;
    for (int k = 0; k < NB; k++) begin
      apply(11, 1 << k);
      chk("R5 power-of-two shift", p, NP'(11) << k);
    end
  endtask

  task automatic t_max;
    apply(15, 15);
    chk("R6 max operands", p, 8'hE1);
    chk("R6 bit7 from final carry", {7'b0, p[7]}, 8'h01);
  endtask

  task automatic t_lsb;
    for (int v = 0; v < 4; v++) begin
      apply(v[0] ? 7 : 6, v[1] ? 9 : 12);
      chk("R2 product bit 0", {7'b0, p[0]}, {7'b0, v[0] & v[1]});
    end
  endtask

  task automatic t_commute;
    logic [NP-1:0] first;
    apply(13, 6);
    first = p;
    apply(6, 13);
    chk("R7 swapped operands", p, first);
  endtask

  task automatic t_comb;
    // R8: no clock edge between driving and sampling.
    @(negedge clk);
    a = 4'd9;
    b = 4'd7;
    #1;
    chk("R8 combinational update", p, 8'd63);
    a = 4'd12;
    #1;
    chk("R8 combinational update", p, 8'd84);
  endtask

  task automatic t_sweep;
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        apply(x, y);
        chk("R1 full sweep", p, exp_prod(x, y));
      end
    end
  endtask

  initial begin
    a = '0;
    b = '0;
    t_zero_state();
    t_identity();
    t_pow2();
    t_max();
    t_lsb();
    t_commute();
    t_comb();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule